// File: doc/BRIEF.md
# On-Screen Display Screen Control Register

This block holds the byte-wide screen control register of an on-screen display engine. Software reaches it through a plain address, data and write-strobe port. The stored bits drive the master display enable, the fade enable and the edge effect. The edge effect is either a border or a drop shadow, chosen by one mode bit that only matters while the effect is switched on.

Two of the bit positions are actions, not settings. Writing a one to either of them sends a single-cycle pulse to the rest of the display engine. One pulse turns off the enable of every window. The other wipes the display memory and clears the colour and blink attributes of every character. These bits are never stored, and they always read back as zero.

The block also drives the fast-blank pin. When the blank-force bit is clear, the pin follows the engine's normal display-active blanking signal. When the bit is set, the pin is forced to a fixed level, which a separate polarity option chooses.

Top module: `osd_scr_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every stored bit is 0. `rd_data` is 0, and `osd_en`, `fade_en`, `border_en`, `shadow_en`, `win_clr` and `mem_clr` are all low.
- R2: A write to the register address sets `osd_en` to data bit 7. The output changes in the cycle after the write edge.
- R3: `border_en` is bit 6 AND NOT bit 5, and `shadow_en` is bit 6 AND bit 5. Both are low whenever bit 6 is 0.
- R4: When stored bit 3 is 1, `fblank_pin` equals `blank_pol`. When bit 3 is 0, `fblank_pin` equals `disp_blank`.
- R5: A write with data bit 2 set raises `win_clr` for exactly the one cycle that follows the write edge.
- R6: A write with data bit 1 set raises `mem_clr` for exactly the one cycle that follows the write edge.
- R7: `rd_data` returns the stored bits 7, 6, 5, 4, 3 and 0, with bits 2 and 1 always 0.
- R8: A write strobe with an address other than `REG_ADDR` changes no stored bit and raises no clear pulse.
- R9: A write to the register address sets `fade_en` to data bit 4.
- R10: A single write that carries clear bits also updates every stored bit in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write address; the register responds at REG_ADDR |
| wr_data | input | 8 | Write data |
| blank_pol | input | 1 | Level the fast-blank pin is forced to while blank-force is set |
| disp_blank | input | 1 | Normal display-active blanking signal |
| rd_data | output | 8 | Readback of the register, with the clear bits read as 0 |
| osd_en | output | 1 | Master display enable |
| fade_en | output | 1 | Fade effect enable |
| border_en | output | 1 | Border effect active |
| shadow_en | output | 1 | Shadow effect active |
| fblank_pin | output | 1 | Fast-blank output pin |
| win_clr | output | 1 | One-cycle pulse that clears all window enables |
| mem_clr | output | 1 | One-cycle pulse that clears display memory and attributes |

## Verification
The bench checks that the shadow-select bit has no effect while the edge effect is off. A design that decoded bit 5 on its own would show a shadow or border with the effect disabled. It writes the two clear bits together with stored settings and then checks that the pulses drop after one cycle and read back as zero. A design that stored them would repeat the clears forever, and a design that dropped the other bits of that write would lose settings. It drives both polarity levels against both blanking levels, with the blank-force bit set and clear, to catch an inverted or swapped pin mux. A strobe to a foreign address must leave everything unchanged, which catches an incomplete address compare.

// File: rtl/osd_ctrl_pkg.sv
// Package: bit positions and stored-state type of the screen control register.
package osd_ctrl_pkg;
    localparam int DATA_W    = 8;
    localparam int BIT_OSD   = 7;
    localparam int BIT_EDGE  = 6;
    localparam int BIT_SHAD  = 5;
    localparam int BIT_FADE  = 4;
    localparam int BIT_BLANK = 3;
    localparam int BIT_WCLR  = 2;
    localparam int BIT_MCLR  = 1;
    localparam int BIT_AUX   = 0;

    // Stored (non-action) bits of the register.
    typedef struct packed {
        logic osd;
        logic edge_en;
        logic shad_sel;
        logic fade;
        logic blank;
        logic aux;
    } ctrl_t;
endpackage

// File: rtl/osd_ctrl_regfile.sv
// Module: register storage and clear-pulse generation.
// Stores the setting bits on an addressed write. Turns the write-one-to-act
// bits into pulses that last one cycle. Assumes the write port is synchronous to clk.
module osd_ctrl_regfile
    import osd_ctrl_pkg::*;
#(
    parameter int          ADDR_W   = 4,
    parameter int unsigned REG_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output ctrl_t             ctrl_q,
    output logic              win_clr,
    output logic              mem_clr
);
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(REG_ADDR);

    logic hit;

    // Purpose: detect a write addressed to this register.
    always_comb hit = wr_en && (wr_addr == MY_ADDR);

    // Purpose: capture the setting bits on an addressed write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (hit) begin
            ctrl_q.osd      <= wr_data[BIT_OSD];
            ctrl_q.edge_en  <= wr_data[BIT_EDGE];
            ctrl_q.shad_sel <= wr_data[BIT_SHAD];
            ctrl_q.fade     <= wr_data[BIT_FADE];
            ctrl_q.blank    <= wr_data[BIT_BLANK];
            ctrl_q.aux      <= wr_data[BIT_AUX];
        end
    end

    // Purpose: one-cycle clear pulses; the action bits are never stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_clr <= 1'b0;
            mem_clr <= 1'b0;
        end else begin
            win_clr <= hit && wr_data[BIT_WCLR];
            mem_clr <= hit && wr_data[BIT_MCLR];
        end
    end

    p_win_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && wr_data[BIT_WCLR]) |=> win_clr);
    p_win_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit && wr_data[BIT_WCLR]) |=> !win_clr);
    p_mem_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && wr_data[BIT_MCLR]) |=> mem_clr);
    p_mem_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit && wr_data[BIT_MCLR]) |=> !mem_clr);
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> $stable(ctrl_q));
    p_osd_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (ctrl_q.osd == $past(wr_data[BIT_OSD])));
    p_fade_store_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (ctrl_q.fade == $past(wr_data[BIT_FADE])));
    p_merge_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && wr_data[BIT_WCLR]) |=> (ctrl_q.edge_en == $past(wr_data[BIT_EDGE])));
endmodule

// File: rtl/osd_ctrl_decode.sv
// Module: effect decode and readback assembly.
// Turns the stored bits into the effect outputs and the readback byte.
// Assumes ctrl comes straight from the register storage.
module osd_ctrl_decode
    import osd_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  ctrl_t             ctrl,
    output logic              osd_en,
    output logic              fade_en,
    output logic              border_en,
    output logic              shadow_en,
    output logic [DATA_W-1:0] rd_data
);
    // Purpose: the edge mode bit acts only while the edge effect is enabled.
    always_comb begin
        osd_en    = ctrl.osd;
        fade_en   = ctrl.fade;
        border_en = ctrl.edge_en && !ctrl.shad_sel;
        shadow_en = ctrl.edge_en &&  ctrl.shad_sel;
    end

    // Purpose: place the stored bits in the readback byte; action bits read 0.
    always_comb begin
        rd_data            = '0;
        rd_data[BIT_OSD]   = ctrl.osd;
        rd_data[BIT_EDGE]  = ctrl.edge_en;
        rd_data[BIT_SHAD]  = ctrl.shad_sel;
        rd_data[BIT_FADE]  = ctrl.fade;
        rd_data[BIT_BLANK] = ctrl.blank;
        rd_data[BIT_AUX]   = ctrl.aux;
    end

    p_mutex_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(border_en && shadow_en));
    p_edge_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[BIT_EDGE] |-> (!border_en && !shadow_en));
    p_rd_action_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[BIT_WCLR] == 1'b0) && (rd_data[BIT_MCLR] == 1'b0));
endmodule

// File: rtl/osd_ctrl_fblank.sv
// Module: fast-blank pin multiplexer.
// Forces the pin to the polarity option level while blank-force is set.
// Otherwise the pin passes the display-active blanking signal through.
// Assumes both inputs are synchronous to clk.
module osd_ctrl_fblank (
    input  logic clk,
    input  logic rst_n,
    input  logic force_blank,
    input  logic blank_pol,
    input  logic disp_blank,
    output logic fblank_pin
);
    // Purpose: choose the forced level or the normal blanking signal.
    always_comb fblank_pin = force_blank ? blank_pol : disp_blank;

    p_forced_r4: assert property (@(posedge clk) disable iff (!rst_n)
        force_blank |-> (fblank_pin == blank_pol));
    p_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !force_blank |-> (fblank_pin == disp_blank));
endmodule

// File: rtl/osd_scr_ctrl.sv
// Module: top of the screen control register.
// Connects the storage, the decode and the fast-blank pin logic.
// Assumes a single clock domain and a synchronous active-low reset.
module osd_scr_ctrl
    import osd_ctrl_pkg::*;
#(
    parameter int          ADDR_W   = 4,
    parameter int unsigned REG_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              blank_pol,
    input  logic              disp_blank,
    output logic [7:0]        rd_data,
    output logic              osd_en,
    output logic              fade_en,
    output logic              border_en,
    output logic              shadow_en,
    output logic              fblank_pin,
    output logic              win_clr,
    output logic              mem_clr
);
    ctrl_t ctrl_q;

    osd_ctrl_regfile #(
        .ADDR_W   (ADDR_W),
        .REG_ADDR (REG_ADDR)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ctrl_q  (ctrl_q),
        .win_clr (win_clr),
        .mem_clr (mem_clr)
    );

    osd_ctrl_decode u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl      (ctrl_q),
        .osd_en    (osd_en),
        .fade_en   (fade_en),
        .border_en (border_en),
        .shadow_en (shadow_en),
        .rd_data   (rd_data)
    );

    osd_ctrl_fblank u_fb (
        .clk         (clk),
        .rst_n       (rst_n),
        .force_blank (ctrl_q.blank),
        .blank_pol   (blank_pol),
        .disp_blank  (disp_blank),
        .fblank_pin  (fblank_pin)
    );

    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (rd_data == '0) && !win_clr && !mem_clr);
endmodule

// File: tb/test_osd_scr_ctrl.sv
module test_osd_scr_ctrl;
    localparam int ADDR_W   = 4;
    localparam int REG_ADDR = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic blank_pol = 1'b0;
    logic disp_blank = 1'b0;
    logic [7:0] rd_data;
    logic osd_en, fade_en, border_en, shadow_en, fblank_pin, win_clr, mem_clr;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    osd_scr_ctrl #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) i_osd_scr_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .blank_pol(blank_pol), .disp_blank(disp_blank),
        .rd_data(rd_data), .osd_en(osd_en), .fade_en(fade_en),
        .border_en(border_en), .shadow_en(shadow_en), .fblank_pin(fblank_pin),
        .win_clr(win_clr), .mem_clr(mem_clr)
    );

    // Entry: wdata[24:17] pol[16] dblank[15] exp_rd[14:7]
    // flags[6:0] = {osd, fade, border, shadow, fblank, win_clr, mem_clr}
    localparam logic [24:0] VEC [10] = '{
        {8'h80, 1'b0, 1'b0, 8'h80, 7'b1000000},
        {8'hC0, 1'b0, 1'b1, 8'hC0, 7'b1010100},
        {8'hE0, 1'b1, 1'b0, 8'hE0, 7'b1001000},
        {8'h20, 1'b1, 1'b1, 8'h20, 7'b0000100},
        {8'h08, 1'b1, 1'b0, 8'h08, 7'b0000100},
        {8'h08, 1'b0, 1'b1, 8'h08, 7'b0000000},
        {8'h04, 1'b0, 1'b0, 8'h00, 7'b0000010},
        {8'h02, 1'b1, 1'b1, 8'h00, 7'b0000101},
        {8'hFF, 1'b0, 1'b1, 8'hF9, 7'b1101011},
        {8'h51, 1'b0, 1'b0, 8'h51, 7'b0110000}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Check every output against a flag vector.
    task automatic chk_flags(input logic [6:0] f);
        chk("R2 osd_en", {7'd0, osd_en}, {7'd0, f[6]});
        chk("R9 fade_en", {7'd0, fade_en}, {7'd0, f[5]});
        chk("R3 border_en", {7'd0, border_en}, {7'd0, f[4]});
        chk("R3 shadow_en", {7'd0, shadow_en}, {7'd0, f[3]});
        chk("R4 fblank_pin", {7'd0, fblank_pin}, {7'd0, f[2]});
        chk("R5 win_clr", {7'd0, win_clr}, {7'd0, f[1]});
        chk("R6 mem_clr", {7'd0, mem_clr}, {7'd0, f[0]});
    endtask

    // One addressed write; sample at the negedge after the write edge.
    task automatic do_write(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 rd_data", rd_data, 8'h00);
        chk_flags(7'b0000000);

        // Table walk: R2 R3 R4 R5 R6 R7 R9 R10
        for (int i = 0; i < 10; i++) begin
            blank_pol  = VEC[i][16];
            disp_blank = VEC[i][15];
            do_write(ADDR_W'(REG_ADDR), VEC[i][24:17]);
            chk("R7 rd_data", rd_data, VEC[i][14:7]);
            chk_flags(VEC[i][6:0]);
            wr_en = 1'b0;
        end

        // R5 R6: pulses last only one cycle
        do_write(ADDR_W'(REG_ADDR), 8'h86);
        chk("R10 rd_data", rd_data, 8'h80);
        chk("R5 win_clr high", {7'd0, win_clr}, 8'h01);
        chk("R6 mem_clr high", {7'd0, mem_clr}, 8'h01);
        wr_en = 1'b0;
        @(negedge clk);
        chk("R5 win_clr dropped", {7'd0, win_clr}, 8'h00);
        chk("R6 mem_clr dropped", {7'd0, mem_clr}, 8'h00);
        chk("R7 clear bits read 0", rd_data, 8'h80);

        // R3: shadow select with edge effect off does nothing
        do_write(ADDR_W'(REG_ADDR), 8'h20);
        wr_en = 1'b0;
        chk("R3 no effect border", {7'd0, border_en}, 8'h00);
        chk("R3 no effect shadow", {7'd0, shadow_en}, 8'h00);

        // R8: foreign address ignored
        do_write(ADDR_W'(REG_ADDR + 1), 8'hFF);
        chk("R8 rd_data unchanged", rd_data, 8'h20);
        chk("R8 no win_clr", {7'd0, win_clr}, 8'h00);
        chk("R8 no mem_clr", {7'd0, mem_clr}, 8'h00);
        wr_en = 1'b0;
        @(negedge clk);
        chk("R8 still unchanged", rd_data, 8'h20);

        // R4: forced pin against blanking signal
        do_write(ADDR_W'(REG_ADDR), 8'h08);
        wr_en = 1'b0;
        blank_pol = 1'b1; disp_blank = 1'b0;
        #1 chk("R4 forced high", {7'd0, fblank_pin}, 8'h01);
        blank_pol = 1'b0; disp_blank = 1'b1;
        #1 chk("R4 forced low", {7'd0, fblank_pin}, 8'h00);

        // R1: reset clears everything again
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 rd_data after reset", rd_data, 8'h00);
        finish_run();
    end
endmodule